// File: doc/BRIEF.md
# Three-Channel Gamma Correction Table Bank

This block applies gamma correction to three independent display pixel streams. Each stream has its own set of three 256-entry, 8-bit tables, one per colour component. A 24-bit RGB pixel that enters a stream has each component replaced by its table entry and leaves two clock cycles later. When a stream's correction enable is clear, the pixel leaves unchanged after the same two cycles. This is the same result an identity table would give.

The host fills the tables through two write strobes. One loads a pointer into the table space, together with a stepping flag. The other stores one byte at the pointer. With stepping on, a whole channel or the whole bank can be streamed after a single pointer write. The table space is one flat range. Channels follow each other, and within a channel the red table comes first, then green, then blue. A small two-state controller holds the pointer mode. Its states are HP_FIXED, where the pointer holds still, and HP_STREAM, where the pointer advances after each stored byte. A pointer write with the flag set takes it to HP_STREAM. A pointer write with the flag clear takes it to HP_FIXED. Data writes never change the state. Reset enters HP_FIXED with the pointer at 0.

Top module: `gamma_lut_bank`

## Requirements
- R1: After reset, no output valid is asserted, the pointer reads 0 and the controller is in HP_FIXED.
- R2: A pointer write loads the 12-bit pointer. If its stepping flag is 1, every later data write stores one byte and then advances the pointer by one.
- R3: If the stepping flag of the last pointer write was 0, data writes all store to the same entry and the pointer does not change.
- R4: Stepping past the last entry, 2303, wraps the pointer to 0.
- R5: Table space layout: the entry for channel c, component k (red 0, green 1, blue 2) and index i sits at pointer c*768 + k*256 + i.
- R6: With a channel's enable set, a pixel presented with its valid high leaves two cycles later with valid high. Each component is replaced by its own table entry, with red in bits 23:16, green in 15:8 and blue in 7:0. Valid is low in every cycle that does not follow a valid input by two cycles.
- R7: With a channel's enable clear, the pixel leaves unchanged with the same two-cycle latency.
- R8: Each channel uses only its own tables and its own enable bit. Channel c's pixels sit in bits c*24+23 down to c*24 of the wide pixel buses.
- R9: If a data write hits the entry that a pixel lookup reads in the same cycle, the output carries either the old byte or the new byte in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ptr_we | input | 1 | Pointer write strobe |
| host_ptr_val | input | 12 | Pointer value to load |
| host_ptr_step | input | 1 | Stepping flag, taken with the pointer write |
| host_data_we | input | 1 | Data write strobe |
| host_data_val | input | 8 | Table byte to store |
| host_ptr_q | output | 12 | Current pointer |
| chan_gamma_en | input | 3 | Per-channel correction enable |
| pix_in_vld | input | 3 | Per-channel input pixel valid |
| pix_in_rgb | input | 72 | Input pixels, 24 bits per channel |
| pix_out_vld | output | 3 | Per-channel output pixel valid |
| pix_out_rgb | output | 72 | Output pixels, 24 bits per channel |

## Verification
Some rules are checked on every cycle by properties: the pointer stays inside the table space, it steps or wraps in HP_STREAM and holds in HP_FIXED, at most one table is written per cycle, valid keeps a two-cycle latency, and a disabled channel returns its input unchanged. Other behaviour only shows up through the bench's scenarios. These cover whether each byte landed at the place the layout requires, whether enabled lookups return the right corrected values, whether channels stay separate, and what a lookup returns when it collides with a write.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
    localparam int CHANNELS = 3;
    localparam int COLOURS  = 3;

    typedef enum logic {
        HP_FIXED  = 1'b0,
        HP_STREAM = 1'b1
    } host_mode_e;
endpackage

// File: rtl/gamma_host_port.sv
module gamma_host_port
    import gamma_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int DW      = 8,
    parameter int SEGS    = CHANNELS * COLOURS,
    parameter int AW      = $clog2(SEGS * ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_we,
    input  logic [AW-1:0]    ptr_val,
    input  logic             ptr_step,
    input  logic             data_we,
    input  logic [DW-1:0]    data_val,
    output logic [AW-1:0]    ptr_q,
    output logic [SEGS-1:0]  wr_seg_en,
    output logic [$clog2(ENTRIES)-1:0] wr_idx,
    output logic [DW-1:0]    wr_data
);
    localparam int IDXW  = $clog2(ENTRIES);
    localparam int SEGW  = AW - IDXW;
    localparam int LAST  = SEGS * ENTRIES - 1;

    host_mode_e mode_q, mode_d;
    logic [SEGW-1:0] seg;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= HP_FIXED;
        else        mode_q <= mode_d;
    end

    // next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            HP_FIXED:  if (ptr_we && ptr_step)  mode_d = HP_STREAM;
            HP_STREAM: if (ptr_we && !ptr_step) mode_d = HP_FIXED;
            default:   mode_d = HP_FIXED;
        endcase
    end

    // pointer register: a pointer load beats stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_we) begin
            ptr_q <= ptr_val;
        end else if (data_we) begin
            unique case (mode_q)
                HP_STREAM: ptr_q <= (ptr_q == AW'(LAST)) ? '0 : ptr_q + AW'(1);
                HP_FIXED:  ptr_q <= ptr_q;
                default:   ptr_q <= ptr_q;
            endcase
        end
    end

    // write strobe decode
    assign seg     = ptr_q[AW-1:IDXW];
    assign wr_idx  = ptr_q[IDXW-1:0];
    assign wr_data = data_val;

    for (genvar s = 0; s < SEGS; s++) begin : g_dec
        assign wr_seg_en[s] = data_we && (seg == SEGW'(s));
    end

    // R4
    ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= AW'(LAST));

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == HP_STREAM && data_we && !ptr_we) |=>
        ptr_q == (($past(ptr_q) == AW'(LAST)) ? AW'(0) : $past(ptr_q) + AW'(1)));

    // R3
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == HP_FIXED && !ptr_we) |=> $stable(ptr_q));

    // R5
    one_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_seg_en));
endmodule

// File: rtl/gamma_table.sv
module gamma_table #(
    parameter int ENTRIES = 256,
    parameter int DW      = 8,
    parameter int IDXW    = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [DW-1:0]   rd_data
);
    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // read-first: a colliding write is seen on the next lookup
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/gamma_chan_pipe.sv
module gamma_chan_pipe
    import gamma_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int DW      = 8,
    parameter int IDXW    = $clog2(ENTRIES),
    parameter int PW      = COLOURS * DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COLOURS-1:0] wr_en,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic               gamma_en,
    input  logic               in_vld,
    input  logic [PW-1:0]      in_rgb,
    output logic               out_vld,
    output logic [PW-1:0]      out_rgb
);
    logic [PW-1:0] looked_up;
    logic [PW-1:0] rgb_d1;
    logic          vld_d1, en_d1;
    logic [1:0]    warm;

    // component k (0 = red) occupies the top slice first
    for (genvar k = 0; k < COLOURS; k++) begin : g_col
        gamma_table #(.ENTRIES(ENTRIES), .DW(DW), .IDXW(IDXW)) u_tab (
            .clk    (clk),
            .wr_en  (wr_en[k]),
            .wr_idx (wr_idx),
            .wr_data(wr_data),
            .rd_idx (in_rgb[(COLOURS-1-k)*DW +: IDXW]),
            .rd_data(looked_up[(COLOURS-1-k)*DW +: DW])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_d1  <= 1'b0;
            en_d1   <= 1'b0;
            rgb_d1  <= '0;
            out_vld <= 1'b0;
            out_rgb <= '0;
        end else begin
            vld_d1  <= in_vld;
            en_d1   <= gamma_en;
            rgb_d1  <= in_rgb;
            out_vld <= vld_d1;
            out_rgb <= en_d1 ? looked_up : rgb_d1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         warm <= '0;
        else if (warm != 2) warm <= warm + 2'd1;
    end

    // R6
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (out_vld == $past(in_vld, 2)));

    // R7
    bypass_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && $past(in_vld, 2) && !$past(gamma_en, 2)) |->
        (out_rgb == $past(in_rgb, 2)));
endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank
    import gamma_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int DW      = 8,
    parameter int SEGS    = CHANNELS * COLOURS,
    parameter int AW      = $clog2(SEGS * ENTRIES),
    parameter int PW      = COLOURS * DW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_ptr_we,
    input  logic [AW-1:0]          host_ptr_val,
    input  logic                   host_ptr_step,
    input  logic                   host_data_we,
    input  logic [DW-1:0]          host_data_val,
    output logic [AW-1:0]          host_ptr_q,
    input  logic [CHANNELS-1:0]    chan_gamma_en,
    input  logic [CHANNELS-1:0]    pix_in_vld,
    input  logic [CHANNELS*PW-1:0] pix_in_rgb,
    output logic [CHANNELS-1:0]    pix_out_vld,
    output logic [CHANNELS*PW-1:0] pix_out_rgb
);
    localparam int IDXW = $clog2(ENTRIES);

    logic [SEGS-1:0] wr_seg_en;
    logic [IDXW-1:0] wr_idx;
    logic [DW-1:0]   wr_data;

    gamma_host_port #(.ENTRIES(ENTRIES), .DW(DW), .SEGS(SEGS), .AW(AW)) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_we   (host_ptr_we),
        .ptr_val  (host_ptr_val),
        .ptr_step (host_ptr_step),
        .data_we  (host_data_we),
        .data_val (host_data_val),
        .ptr_q    (host_ptr_q),
        .wr_seg_en(wr_seg_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    // channel c owns table segments c*COLOURS .. c*COLOURS+COLOURS-1
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        gamma_chan_pipe #(.ENTRIES(ENTRIES), .DW(DW), .IDXW(IDXW), .PW(PW)) u_pipe (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_seg_en[c*COLOURS +: COLOURS]),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .gamma_en(chan_gamma_en[c]),
            .in_vld  (pix_in_vld[c]),
            .in_rgb  (pix_in_rgb[c*PW +: PW]),
            .out_vld (pix_out_vld[c]),
            .out_rgb (pix_out_rgb[c*PW +: PW])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pix_out_vld == '0 && host_ptr_q == '0));
endmodule

// File: tb/gamma_lut_bank_bench.sv
module gamma_lut_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_ptr_we = 1'b0;
    logic [11:0] host_ptr_val = '0;
    logic        host_ptr_step = 1'b0;
    logic        host_data_we = 1'b0;
    logic [7:0]  host_data_val = '0;
    logic [11:0] host_ptr_q;
    logic [2:0]  chan_gamma_en = '0;
    logic [2:0]  pix_in_vld = '0;
    logic [71:0] pix_in_rgb = '0;
    logic [2:0]  pix_out_vld;
    logic [71:0] pix_out_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gamma_lut_bank u_gamma_lut_bank (
        .clk(clk), .rst_n(rst_n),
        .host_ptr_we(host_ptr_we), .host_ptr_val(host_ptr_val),
        .host_ptr_step(host_ptr_step), .host_data_we(host_data_we),
        .host_data_val(host_data_val), .host_ptr_q(host_ptr_q),
        .chan_gamma_en(chan_gamma_en), .pix_in_vld(pix_in_vld),
        .pix_in_rgb(pix_in_rgb), .pix_out_vld(pix_out_vld),
        .pix_out_rgb(pix_out_rgb)
    );

    // {channel, enable, input pixel, expected pixel}; tables hold i ^ (0x11*(seg+1))
    localparam logic [50:0] VEC [9] = '{
        {2'd0, 1'b1, 24'h102030, 24'h010203},
        {2'd1, 1'b1, 24'h445566, 24'h000000},
        {2'd2, 1'b1, 24'hFF0099, 24'h888800},
        {2'd0, 1'b0, 24'hABCDEF, 24'hABCDEF},
        {2'd1, 1'b0, 24'h123456, 24'h123456},
        {2'd2, 1'b0, 24'h000000, 24'h000000},
        {2'd1, 1'b1, 24'h00FF80, 24'h44AAE6},
        {2'd2, 1'b1, 24'h010203, 24'h768A9A},
        {2'd0, 1'b1, 24'hFFFFFF, 24'hEEDDCC}
    };

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic ptr_write(logic [11:0] v, logic step);
        @(negedge clk);
        host_ptr_we = 1'b1; host_ptr_val = v; host_ptr_step = step;
        @(negedge clk);
        host_ptr_we = 1'b0;
    endtask

    task automatic data_write(logic [7:0] v);
        @(negedge clk);
        host_data_we = 1'b1; host_data_val = v;
        @(negedge clk);
        host_data_we = 1'b0;
    endtask

    // presents one pixel, returns output two edges later and valid one cycle after
    task automatic run_pix(int ch, logic en, logic [23:0] rgb,
                           output logic [23:0] got, output logic v_at, output logic v_after);
        @(negedge clk);
        chan_gamma_en = '0;
        chan_gamma_en[ch] = en;
        pix_in_vld = '0;
        pix_in_vld[ch] = 1'b1;
        pix_in_rgb[ch*24 +: 24] = rgb;
        @(posedge clk);
        @(negedge clk);
        pix_in_vld = '0;
        @(posedge clk);
        @(negedge clk);
        got  = pix_out_rgb[ch*24 +: 24];
        v_at = pix_out_vld[ch];
        @(negedge clk);
        v_after = pix_out_vld[ch];
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual %0d expected below 100000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [23:0] got;
        logic va, vb;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out valid", {29'd0, pix_out_vld}, 32'd0);
        check("R1 pointer", {20'd0, host_ptr_q}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pointer after release", {20'd0, host_ptr_q}, 32'd0);

        // R2 R5: stream whole bank from pointer 0
        ptr_write(12'd0, 1'b1);
        for (int s = 0; s < 9; s++) begin
            for (int i = 0; i < 256; i++) begin
                @(negedge clk);
                host_data_we  = 1'b1;
                host_data_val = 8'(i) ^ (8'h11 * 8'(s + 1));
            end
        end
        @(negedge clk);
        host_data_we = 1'b0;
        // R4: 2304 steps land back at 0
        check("R4 pointer after full stream", {20'd0, host_ptr_q}, 32'd0);

        ptr_write(12'd100, 1'b1);
        data_write(8'h64 ^ 8'h11);
        check("R2 pointer stepped", {20'd0, host_ptr_q}, 32'd101);

        // R5 R6 R7 R8: vector walk
        foreach (VEC[n]) begin
            run_pix(int'(VEC[n][50:49]), VEC[n][48], VEC[n][47:24], got, va, vb);
            check($sformatf("R6/R7/R5 vec %0d data", n), {8'd0, got}, {8'd0, VEC[n][23:0]});
            check($sformatf("R6 vec %0d valid", n), {31'd0, va}, 32'd1);
            check($sformatf("R6 vec %0d valid drops", n), {31'd0, vb}, 32'd0);
        end

        // R8: two channels at once, only channel 0 corrected
        @(negedge clk);
        chan_gamma_en = 3'b001;
        pix_in_vld = 3'b101;
        pix_in_rgb[23:0]  = 24'h102030;
        pix_in_rgb[71:48] = 24'h123456;
        @(posedge clk);
        @(negedge clk);
        pix_in_vld = '0;
        @(posedge clk);
        @(negedge clk);
        check("R8 ch0 corrected", {8'd0, pix_out_rgb[23:0]}, 32'h010203);
        check("R8 ch2 bypassed", {8'd0, pix_out_rgb[71:48]}, 32'h123456);
        check("R8 ch1 idle", {31'd0, pix_out_vld[1]}, 32'd0);

        // R3: fixed pointer, three writes to entry 5 of channel 0 red
        ptr_write(12'd5, 1'b0);
        data_write(8'hAA);
        data_write(8'hBB);
        data_write(8'hCC);
        check("R3 pointer held", {20'd0, host_ptr_q}, 32'd5);
        run_pix(0, 1'b1, 24'h050505, got, va, vb);
        check("R3 last write kept", {8'd0, got}, 32'hCC2736);

        // R4: wrap at the final entry
        ptr_write(12'd2303, 1'b1);
        data_write(8'h5A);
        check("R4 wrap to zero", {20'd0, host_ptr_q}, 32'd0);
        data_write(8'h6B);
        check("R4 step after wrap", {20'd0, host_ptr_q}, 32'd1);
        run_pix(2, 1'b1, 24'h0000FF, got, va, vb);
        check("R4 R5 last entry", {8'd0, got}, 32'h77885A);
        run_pix(0, 1'b1, 24'h000000, got, va, vb);
        check("R4 R5 first entry", {8'd0, got}, 32'h6B2233);

        // R9: write collides with lookup of channel 1 green index 0x40
        ptr_write(12'd1088, 1'b0);
        @(negedge clk);
        chan_gamma_en = 3'b010;
        pix_in_vld = 3'b010;
        pix_in_rgb[47:24] = 24'h004000;
        host_data_we = 1'b1;
        host_data_val = 8'h3C;
        @(posedge clk);
        @(negedge clk);
        pix_in_vld = '0;
        host_data_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pix_out_rgb[39:32] !== 8'h15 && pix_out_rgb[39:32] !== 8'h3C) begin
            errors++;
            $display("FAIL R9 actual %h expected 15 or 3c", pix_out_rgb[39:32]);
        end
        run_pix(1, 1'b1, 24'h004000, got, va, vb);
        check("R9 new value after", {8'd0, got}, 32'h443C66);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule